// File: doc/BRIEF.md
# Receive-Threshold Hardware Flow Control

This block handles hardware handshaking for a serial port. It sits between a 16-entry receive FIFO, a character serializer and the two modem handshake lines. On the receive side it compares the FIFO fill count against a trigger threshold. Software picks that threshold from four values. The block then tells the remote sender, through the request-to-send output, whether it may keep sending. On the transmit side it synchronizes the incoming clear-to-send line. It also holds a valid/ready start handshake with the serializer, so a new character is only launched when the remote end permits it.

A mode input selects hardware control of both lines. With that mode off, the request-to-send output simply mirrors a software request bit, and clear-to-send is not looked at. Clear-to-send only affects transmission at character boundaries. Once a character has been accepted, it runs to completion and the serializer reports the end with a one-cycle done pulse. The start handshake follows valid/ready rules. The serializer raises `tx_start_valid` and holds it until a cycle where `tx_start_ready` is also high; that cycle is the transfer. `tx_start_ready` is never high while a character is in flight, so back-pressure lasts at least until the done pulse.

Top module: `rx_tx_flowctl`

## Requirements
- R1: While `rst_n` is low, `rts_o` is 0 and `tx_busy` is 0. Right after reset, with `flow_auto` high, `tx_start_ready` is 0 until a high `cts_i` has been synchronized.
- R2: `trig_sel` picks the threshold: 0 = 1 entry, 1 = 4 entries, 2 = 8 entries, 3 = 14 entries, for a FIFO depth of 16.
- R3: With `flow_auto` high, `rts_o` is 0 one clock after `rx_level` is at or above the selected threshold. This holds whatever the value of `rts_sw`.
- R4: With `flow_auto` high, `rts_o` returns to 1 one clock after `rx_level` falls below the selected threshold.
- R5: With `flow_auto` low, `rts_o` equals `rts_sw` one clock later, whatever the values of `rx_level` and `trig_sel`.
- R6: `cts_i` (1 = remote allows sending) passes through two flops. A change on it reaches `tx_start_ready` after exactly two rising edges, and not after one.
- R7: With `flow_auto` high and synchronized `cts_i` at 0, `tx_start_ready` is 0 and no character starts.
- R8: A transfer (`tx_start_valid` and `tx_start_ready` both high at an edge) sets `tx_busy`. `tx_busy` stays 1 until an edge with `tx_char_done` high, even if `cts_i` drops in the meantime.
- R9: With `flow_auto` low, `cts_i` has no effect: `tx_start_ready` is exactly the inverse of `tx_busy`.
- R10: `tx_start_ready` is 0 whenever `tx_busy` is 1. `tx_busy` clears one clock after the done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flow_auto | input | 1 | 1 = hardware flow control on both lines |
| rts_sw | input | 1 | Software request-to-send value, used when `flow_auto` is 0 |
| trig_sel | input | 2 | Receive threshold select (see R2) |
| rx_level | input | 5 | Current receive FIFO fill count, 0..16 |
| cts_i | input | 1 | Clear-to-send from remote, 1 = may send (asynchronous) |
| tx_start_valid | input | 1 | Serializer has a character ready to start |
| tx_start_ready | output | 1 | Start is allowed this cycle |
| tx_char_done | input | 1 | One-cycle pulse when the running character's last stop bit ends |
| tx_busy | output | 1 | A character is in flight |
| rts_o | output | 1 | Request-to-send to remote, 1 = may send to us |

## Verification
`rts_o` is registered, so the bench drives levels and mode bits on a falling edge and checks `rts_o` on the next falling edge, one rising edge later. Clear-to-send changes are checked on both sides of the synchronizer: once after one rising edge, where the old value must still hold, and once after the second, where the new value must appear. `tx_start_ready` is combinational from `tx_busy` and the synchronized line. For that reason each start or done pulse is checked on the falling edge right after the rising edge that consumes it.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
  // Receive threshold selector codes
  typedef enum logic [1:0] {
    TRIG_A = 2'd0,
    TRIG_B = 2'd1,
    TRIG_C = 2'd2,
    TRIG_D = 2'd3
  } trig_code_e;
endpackage

// File: rtl/flow_cts_sync.sv
module flow_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/flow_rts_gen.sv
module flow_rts_gen
  import flowctl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TH_A  = 1,
  parameter int TH_B  = 4,
  parameter int TH_C  = 8,
  parameter int TH_D  = 14,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flow_auto,
  input  logic          rts_sw,
  input  logic [1:0]    trig_sel,
  input  logic [LW-1:0] rx_level,
  output logic          rts_o
);
  logic [LW-1:0] thresh;
  logic          below;
  logic          rts_d;

  always_comb begin
    unique case (trig_code_e'(trig_sel))
      TRIG_A:  thresh = LW'(TH_A);
      TRIG_B:  thresh = LW'(TH_B);
      TRIG_C:  thresh = LW'(TH_C);
      default: thresh = LW'(TH_D);
    endcase
  end

  assign below = (rx_level < thresh);
  assign rts_d = flow_auto ? below : rts_sw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_o <= 1'b0;
    else        rts_o <= rts_d;
  end

  AST_RTS_FULL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_auto && rx_level >= LW'(TH_D)) |=> !rts_o); // R3
  AST_RTS_EMPTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_auto && rx_level == '0) |=> rts_o); // R4
  AST_RTS_SW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_auto) |=> (rts_o == $past(rts_sw))); // R5
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LW'(DEPTH)); // R2
endmodule

// File: rtl/flow_tx_gate.sv
module flow_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic flow_auto,
  input  logic cts_ok,
  input  logic tx_start_valid,
  input  logic tx_char_done,
  output logic tx_start_ready,
  output logic tx_busy
);
  logic permit;
  logic take;

  assign permit         = !flow_auto || cts_ok;
  assign tx_start_ready = !tx_busy && permit;
  assign take           = tx_start_valid && tx_start_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            tx_busy <= 1'b0;
    else if (take)         tx_busy <= 1'b1;
    else if (tx_char_done) tx_busy <= 1'b0;
  end

  AST_NO_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_auto && !cts_ok) |-> !tx_start_ready); // R7
  AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tx_char_done) |=> tx_busy); // R8
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start_valid && tx_start_ready) |=> tx_busy); // R8
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !tx_start_ready); // R10
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && tx_char_done) |=> !tx_busy); // R10
endmodule

// File: rtl/rx_tx_flowctl.sv
module rx_tx_flowctl #(
  parameter int DEPTH       = 16,
  parameter int TH_A        = 1,
  parameter int TH_B        = 4,
  parameter int TH_C        = 8,
  parameter int TH_D        = 14,
  parameter int SYNC_STAGES = 2,
  localparam int LW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flow_auto,
  input  logic          rts_sw,
  input  logic [1:0]    trig_sel,
  input  logic [LW-1:0] rx_level,
  input  logic          cts_i,
  input  logic          tx_start_valid,
  output logic          tx_start_ready,
  input  logic          tx_char_done,
  output logic          tx_busy,
  output logic          rts_o
);
  logic cts_s;

  flow_rts_gen #(
    .DEPTH(DEPTH), .TH_A(TH_A), .TH_B(TH_B), .TH_C(TH_C), .TH_D(TH_D)
  ) u_rts (
    .clk(clk), .rst_n(rst_n), .flow_auto(flow_auto), .rts_sw(rts_sw),
    .trig_sel(trig_sel), .rx_level(rx_level), .rts_o(rts_o)
  );

  flow_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(cts_i), .sync_o(cts_s)
  );

  flow_tx_gate u_gate (
    .clk(clk), .rst_n(rst_n), .flow_auto(flow_auto), .cts_ok(cts_s),
    .tx_start_valid(tx_start_valid), .tx_char_done(tx_char_done),
    .tx_start_ready(tx_start_ready), .tx_busy(tx_busy)
  );

  AST_OFF_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_auto |-> (tx_start_ready == !tx_busy)); // R9
endmodule

// File: tb/rx_tx_flowctl_bench.sv
module rx_tx_flowctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flow_auto = 1'b0, rts_sw = 1'b0;
  logic [1:0] trig_sel = 2'd0;
  logic [4:0] rx_level = 5'd0;
  logic       cts_i = 1'b0, tx_start_valid = 1'b0, tx_char_done = 1'b0;
  logic       tx_start_ready, tx_busy, rts_o;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rx_tx_flowctl u_rx_tx_flowctl (
    .clk(clk), .rst_n(rst_n), .flow_auto(flow_auto), .rts_sw(rts_sw),
    .trig_sel(trig_sel), .rx_level(rx_level), .cts_i(cts_i),
    .tx_start_valid(tx_start_valid), .tx_start_ready(tx_start_ready),
    .tx_char_done(tx_char_done), .tx_busy(tx_busy), .rts_o(rts_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  // {flow_auto, rts_sw, trig_sel[1:0], rx_level[4:0], expected rts}
  localparam logic [9:0] VEC [16] = '{
    {1'b1,1'b0,2'd0,5'd0, 1'b1},  // R4 below 1
    {1'b1,1'b0,2'd0,5'd1, 1'b0},  // R3 at 1
    {1'b1,1'b0,2'd1,5'd3, 1'b1},  // R2 thr 4
    {1'b1,1'b0,2'd1,5'd4, 1'b0},
    {1'b1,1'b0,2'd2,5'd7, 1'b1},  // R2 thr 8
    {1'b1,1'b0,2'd2,5'd8, 1'b0},
    {1'b1,1'b1,2'd3,5'd13,1'b1},  // R2 thr 14
    {1'b1,1'b1,2'd3,5'd14,1'b0},  // R3 sw bit ignored
    {1'b1,1'b0,2'd3,5'd16,1'b0},  // R3 full
    {1'b1,1'b0,2'd2,5'd9, 1'b0},
    {1'b1,1'b0,2'd2,5'd2, 1'b1},  // R4 drained
    {1'b0,1'b0,2'd0,5'd0, 1'b0},  // R5
    {1'b0,1'b1,2'd0,5'd16,1'b1},  // R5 level ignored
    {1'b0,1'b1,2'd3,5'd0, 1'b1},
    {1'b0,1'b0,2'd3,5'd15,1'b0},
    {1'b1,1'b0,2'd0,5'd16,1'b0}
  };

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    flow_auto = 1'b1;
    repeat (3) step();
    chk("R1 rts in reset", rts_o, 0);
    chk("R1 busy in reset", tx_busy, 0);
    rst_n = 1'b1;
    step();
    chk("R1 ready after reset, cts low", tx_start_ready, 0);

    for (int i = 0; i < 16; i++) begin
      {flow_auto, rts_sw, trig_sel, rx_level} = VEC[i][9:1];
      step();
      chk(VEC[i][9] ? (VEC[i][0] ? "R4/R2 rts high" : "R3/R2 rts low")
                    : "R5 rts follows sw", rts_o, VEC[i][0]);
    end

    // R6: two-flop delay on clear-to-send
    flow_auto = 1'b1; cts_i = 1'b0;
    repeat (3) step();
    chk("R7 ready with cts low", tx_start_ready, 0);
    cts_i = 1'b1;
    step();
    chk("R6 ready after one edge", tx_start_ready, 0);
    step();
    chk("R6 ready after two edges", tx_start_ready, 1);

    // R8: start a character, then drop cts mid-character
    tx_start_valid = 1'b1;
    step();
    tx_start_valid = 1'b0;
    chk("R8 busy after start", tx_busy, 1);
    chk("R10 ready low while busy", tx_start_ready, 0);
    cts_i = 1'b0;
    repeat (4) step();
    chk("R8 busy held with cts low", tx_busy, 1);
    tx_char_done = 1'b1;
    step();
    tx_char_done = 1'b0;
    chk("R10 busy clears after done", tx_busy, 0);
    chk("R7 no restart with cts low", tx_start_ready, 0);
    tx_start_valid = 1'b1;
    repeat (2) step();
    chk("R7 valid held, no start", tx_busy, 0);
    tx_start_valid = 1'b0;

    // R9: flow control off, cts ignored
    flow_auto = 1'b0;
    #1;
    chk("R9 ready with cts low, mode off", tx_start_ready, 1);
    tx_start_valid = 1'b1;
    step();
    tx_start_valid = 1'b0;
    chk("R9 start taken with cts low", tx_busy, 1);
    chk("R9 ready low while busy", tx_start_ready, 0);
    tx_char_done = 1'b1;
    step();
    tx_char_done = 1'b0;
    chk("R9 ready back after done", tx_start_ready, 1);

    // R1 again: mid-run reset
    rts_sw = 1'b1; step();
    rst_n = 1'b0; #1;
    chk("R1 rts cleared by reset", rts_o, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule